// File: doc/BRIEF.md
# Saturating Doubling Widening Multiply-Accumulate Unit

This block executes one scalar signed multiply in which two narrow elements (16 or 32 bits) are multiplied, doubled and widened to twice the element width. It has three flavours: the bare doubled product, the doubled product added to a wide accumulator, and the doubled product subtracted from that accumulator. The caller presents a decoded 32-bit instruction word, the first narrow operand, the whole register that holds the second operand, and the wide accumulator. The second operand is taken either from lane 0 of that register (register form) or from a lane picked by an index packed into the instruction (by-element form).

Both the doubling and the accumulation saturate to the signed range of the wide element, and either event sets a sticky saturation flag that only a reset can clear. The result returns one cycle after the input pulse, zero-extended to the full register width, with a write strobe. It also returns the decoded number of the register that supplies the second operand. Encodings that are not legal return an undefined indication with no write and no change to the flag.

Top module: `sat_dbl_mac`

## Requirements
- R1: An instruction whose size field (bits 23:22) is 00 or 11, or whose fixed fields match neither form, raises `undef` with `wrEn` low. `result` and `satFlag` keep their previous values.
- R2: Register form: bits 31:29 = 010, bits 28:24 = 11110, bit 21 = 1, bits 11:10 = 00. Opcode bits 15:12 select the mode: 1101 for product, 1001 for add, 1011 for subtract. The second operand is lane 0 of `regM`, and `srcRegNum` is bits 20:16.
- R3: By-element form: bits 31:29 = 010, bits 28:24 = 11111, bit 10 = 0. Opcode bits 15:12 select the mode: 1011 for product, 0011 for add, 0111 for subtract.
- R4: By-element form with 16-bit elements (size 01): the operand is the 16-bit lane {bit11, bit21, bit20} of `regM`, and `srcRegNum` is {0, bits 19:16}.
- R5: By-element form with 32-bit elements (size 10): the operand is the 32-bit lane {bit11, bit21} of `regM`, and `srcRegNum` is bits 20:16.
- R6: The product is 2·a·b, with a and b taken as signed narrow values (`opA` bits 15:0 for 16-bit elements, bits 31:0 for 32-bit elements). It saturates to the wide maximum only when both inputs are the narrow minimum.
- R7: Add and subtract use the wide low part of `acc` (32 or 64 bits) and clamp to the signed wide minimum or maximum.
- R8: Every bit of `result` above the wide element is zero.
- R9: `satFlag` is set by a saturation in either the doubling step or the accumulate step. It stays set until reset.
- R10: `outValid` is high exactly one cycle after each `inValid` pulse. On a legal instruction, `wrEn` is high in that cycle.
- R11: A synchronous reset clears `satFlag`, `outValid`, `wrEn`, `undef` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | One-cycle strobe: operands and instruction present |
| instr | input | 32 | Instruction word |
| opA | input | 32 | First narrow operand (low 16 bits used for 16-bit elements) |
| regM | input | REG_W | Register holding the second operand's lanes |
| acc | input | 64 | Wide accumulator (low 32 bits used for 16-bit elements) |
| outValid | output | 1 | Result cycle marker |
| wrEn | output | 1 | Destination write strobe |
| undef | output | 1 | Instruction encoding was not legal |
| srcRegNum | output | 5 | Decoded second-operand register number |
| result | output | REG_W | Wide result, upper bits zero |
| satFlag | output | 1 | Sticky saturation flag |

## Verification
Small mixed-sign operands in product mode confirm the basic doubling and sign extension, with garbage placed in the ignored upper half of `opA` and `acc`. Minimum-times-minimum inputs separate the doubling saturation from the accumulate saturation. A case that saturates only in the product and then stays in range after the add shows that the flag comes from either stage. By-element cases put the operand in a high lane, surrounded by filler lanes, which exposes wrong lane or register-number reconstruction for each element size. Illegal sizes and broken fixed fields, issued after a saturating operation, show that no write and no flag change occur.

// File: rtl/sat_dbl_mac_pkg.sv
package sat_dbl_mac_pkg;

  typedef enum logic [1:0] {
    MODE_MUL = 2'd0,
    MODE_ADD = 2'd1,
    MODE_SUB = 2'd2
  } mode_e;

  // Strobes from decode to datapath
  typedef struct packed {
    logic       go;
    logic       legal;
    logic       wordSel;   // 0: 16-bit elements, 1: 32-bit elements
    mode_e      mode;
    logic [2:0] lane;
    logic [4:0] regNum;
  } ctl_t;

endpackage

// File: rtl/sat_dbl_mac_ctrl.sv
module sat_dbl_mac_ctrl
  import sat_dbl_mac_pkg::*;
(
  input  logic        inValid,
  input  logic [31:0] instr,
  output ctl_t        ctl
);

  logic [1:0] sizeFld;
  logic [3:0] opc;
  logic       rrForm, beForm, sizeOk, rrOpOk, beOpOk;
  mode_e      rrMode, beMode;

  always_comb begin
    sizeFld = instr[23:22];
    opc     = instr[15:12];
    rrForm  = (instr[31:29] == 3'b010) && (instr[28:24] == 5'b11110) &&
              instr[21] && (instr[11:10] == 2'b00);
    beForm  = (instr[31:29] == 3'b010) && (instr[28:24] == 5'b11111) &&
              !instr[10];
    sizeOk  = (sizeFld == 2'b01) || (sizeFld == 2'b10);

    rrOpOk = 1'b1;
    unique case (opc)
      4'b1101: rrMode = MODE_MUL;
      4'b1001: rrMode = MODE_ADD;
      4'b1011: rrMode = MODE_SUB;
      default: begin rrMode = MODE_MUL; rrOpOk = 1'b0; end
    endcase

    beOpOk = 1'b1;
    unique case (opc)
      4'b1011: beMode = MODE_MUL;
      4'b0011: beMode = MODE_ADD;
      4'b0111: beMode = MODE_SUB;
      default: begin beMode = MODE_MUL; beOpOk = 1'b0; end
    endcase

    ctl.go      = inValid;
    ctl.legal   = sizeOk && ((rrForm && rrOpOk) || (beForm && beOpOk));
    ctl.wordSel = sizeFld[1];
    ctl.mode    = beForm ? beMode : rrMode;
    if (!beForm)
      ctl.lane = 3'd0;
    else if (sizeFld == 2'b01)
      ctl.lane = {instr[11], instr[21], instr[20]};
    else
      ctl.lane = {1'b0, instr[11], instr[21]};
    if (beForm && (sizeFld == 2'b01))
      ctl.regNum = {1'b0, instr[19:16]};
    else
      ctl.regNum = instr[20:16];
  end

endmodule

// File: rtl/sat_dbl_mac_dp.sv
module sat_dbl_mac_dp
  import sat_dbl_mac_pkg::*;
#(
  parameter int REG_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  ctl_t             ctl,
  input  logic [31:0]      opA,
  input  logic [REG_W-1:0] regM,
  input  logic [63:0]      acc,
  output logic             outValid,
  output logic             wrEn,
  output logic             undef,
  output logic [4:0]       srcRegNum,
  output logic [REG_W-1:0] result,
  output logic             satFlag
);

  localparam int EXT_W = 66;
  localparam int PAD_W = REG_W - 64;

  logic [15:0]             bHalf;
  logic [31:0]             bWord;
  logic signed [EXT_W-1:0] aExt, bExt, prodDbl, wideMax, wideMin;
  logic signed [EXT_W-1:0] prodClamped, accExt, sumRaw, sumClamped;
  logic                    prodSat, accSat, wordQ;
  logic [63:0]             wideRes;

  always_comb begin
    bHalf = regM[{ctl.lane, 4'b0000} +: 16];
    bWord = regM[{ctl.lane[1:0], 5'b00000} +: 32];
    aExt  = ctl.wordSel ? {{34{opA[31]}}, opA} : {{50{opA[15]}}, opA[15:0]};
    bExt  = ctl.wordSel ? {{34{bWord[31]}}, bWord} : {{50{bHalf[15]}}, bHalf};
    prodDbl = (aExt * bExt) <<< 1;
    wideMax = ctl.wordSel ? {3'b000, {63{1'b1}}} : {35'd0, {31{1'b1}}};
    wideMin = ~wideMax;
    prodSat     = prodDbl > wideMax;
    prodClamped = prodSat ? wideMax : prodDbl;
    accExt = ctl.wordSel ? {{2{acc[63]}}, acc} : {{34{acc[31]}}, acc[31:0]};
    unique case (ctl.mode)
      MODE_ADD: sumRaw = accExt + prodClamped;
      MODE_SUB: sumRaw = accExt - prodClamped;
      default:  sumRaw = prodClamped;
    endcase
    accSat = (sumRaw > wideMax) || (sumRaw < wideMin);
    if (sumRaw > wideMax)      sumClamped = wideMax;
    else if (sumRaw < wideMin) sumClamped = wideMin;
    else                       sumClamped = sumRaw;
    wideRes = ctl.wordSel ? sumClamped[63:0] : {32'd0, sumClamped[31:0]};
  end

  // R6: doubling can overflow only for two equal negative inputs
  always_comb begin
    a_r6_dbl_sat_only_min: assert (!prodSat || ((aExt == bExt) && (aExt < 0)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      wrEn      <= 1'b0;
      undef     <= 1'b0;
      satFlag   <= 1'b0;
      srcRegNum <= 5'd0;
      result    <= '0;
      wordQ     <= 1'b0;
    end else begin
      outValid <= ctl.go;
      wrEn     <= ctl.go && ctl.legal;
      undef    <= ctl.go && !ctl.legal;
      if (ctl.go && ctl.legal) begin
        result    <= {{PAD_W{1'b0}}, wideRes};
        srcRegNum <= ctl.regNum;
        wordQ     <= ctl.wordSel;
        satFlag   <= satFlag | prodSat | accSat;
      end
    end
  end

  a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
    ctl.go |=> outValid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !ctl.go |=> !outValid);
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    satFlag |=> satFlag);
  a_r1_no_write: assert property (@(posedge clk) disable iff (rst)
    (outValid && undef) |-> !wrEn);
  a_r1_flag_kept: assert property (@(posedge clk) disable iff (rst)
    (outValid && undef) |-> $stable(satFlag));
  a_r8_upper_clear_h: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !wordQ) |-> (result[REG_W-1:32] == '0));
  a_r8_upper_clear_s: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wordQ) |-> (result[REG_W-1:64] == '0));

endmodule

// File: rtl/sat_dbl_mac.sv
module sat_dbl_mac
  import sat_dbl_mac_pkg::*;
#(
  parameter int REG_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [31:0]      instr,
  input  logic [31:0]      opA,
  input  logic [REG_W-1:0] regM,
  input  logic [63:0]      acc,
  output logic             outValid,
  output logic             wrEn,
  output logic             undef,
  output logic [4:0]       srcRegNum,
  output logic [REG_W-1:0] result,
  output logic             satFlag
);

  ctl_t ctl;

  sat_dbl_mac_ctrl u_ctrl (
    .inValid (inValid),
    .instr   (instr),
    .ctl     (ctl)
  );

  sat_dbl_mac_dp #(.REG_W(REG_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .opA       (opA),
    .regM      (regM),
    .acc       (acc),
    .outValid  (outValid),
    .wrEn      (wrEn),
    .undef     (undef),
    .srcRegNum (srcRegNum),
    .result    (result),
    .satFlag   (satFlag)
  );

endmodule

// File: tb/sat_dbl_mac_tb.sv
module sat_dbl_mac_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [31:0]  instr = '0;
  logic [31:0]  opA = '0;
  logic [127:0] regM = '0;
  logic [63:0]  acc = '0;
  logic         outValid, wrEn, undef, satFlag;
  logic [4:0]   srcRegNum;
  logic [127:0] result;

  int testsRun = 0;
  int testsFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sat_dbl_mac u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .instr(instr), .opA(opA),
    .regM(regM), .acc(acc), .outValid(outValid), .wrEn(wrEn),
    .undef(undef), .srcRegNum(srcRegNum), .result(result), .satFlag(satFlag)
  );

  // form, size, mode, lane, reg, a, b, acc, expected, sat
  localparam int NV = 12;
  localparam logic [205:0] VEC [NV] = '{
    {1'b0, 2'b01, 2'd0, 3'd0, 5'd13, 32'h3,        32'hFFFB,     64'h0,                 64'h00000000FFFFFFE2, 1'b0},
    {1'b0, 2'b01, 2'd0, 3'd0, 5'd13, 32'h8000,     32'h8000,     64'h0,                 64'h000000007FFFFFFF, 1'b1},
    {1'b0, 2'b01, 2'd1, 3'd0, 5'd2,  32'h64,       32'hC8,       64'hDEADBEEF12345678,  64'h000000001234F2B8, 1'b0},
    {1'b0, 2'b01, 2'd1, 3'd0, 5'd2,  32'h4000,     32'h4000,     64'h7FFFFFF0,          64'h000000007FFFFFFF, 1'b1},
    {1'b0, 2'b01, 2'd2, 3'd0, 5'd2,  32'h4000,     32'h4000,     64'h80000010,          64'h0000000080000000, 1'b1},
    {1'b0, 2'b10, 2'd0, 3'd0, 5'd31, 32'h80000000, 32'h80000000, 64'h0,                 64'h7FFFFFFFFFFFFFFF, 1'b1},
    {1'b0, 2'b10, 2'd2, 3'd0, 5'd31, 32'h2,        32'h3,        64'd100,               64'd88,               1'b0},
    {1'b1, 2'b01, 2'd0, 3'd5, 5'd9,  32'h7,        32'hFFFF,     64'h0,                 64'h00000000FFFFFFF2, 1'b0},
    {1'b1, 2'b10, 2'd1, 3'd3, 5'd23, 32'hFFFFFFFD, 32'h4,        64'h1,                 64'hFFFFFFFFFFFFFFE9, 1'b0},
    {1'b0, 2'b01, 2'd1, 3'd0, 5'd4,  32'h8000,     32'h8000,     64'hFFFFFFFF,          64'h000000007FFFFFFE, 1'b1},
    {1'b1, 2'b10, 2'd2, 3'd2, 5'd17, 32'h80000000, 32'h80000000, 64'h0,                 64'h8000000000000001, 1'b1},
    {1'b1, 2'b01, 2'd1, 3'd0, 5'd3,  32'h1,        32'h1,        64'h7FFFFFFE,          64'h000000007FFFFFFF, 1'b1}
  };

  function automatic logic [31:0] mkInstr(input logic beForm, input logic [1:0] sz,
                                          input logic [1:0] md, input logic [2:0] ln,
                                          input logic [4:0] rg);
    logic [3:0] oc;
    logic h, l, m;
    if (!beForm) begin
      oc = (md == 2'd0) ? 4'b1101 : (md == 2'd1) ? 4'b1001 : 4'b1011;
      return {3'b010, 5'b11110, sz, 1'b1, rg, oc, 2'b00, 5'd1, 5'd2};
    end
    oc = (md == 2'd0) ? 4'b1011 : (md == 2'd1) ? 4'b0011 : 4'b0111;
    if (sz == 2'b01) begin h = ln[2]; l = ln[1]; m = ln[0]; end
    else begin h = ln[1]; l = ln[0]; m = rg[4]; end
    return {3'b010, 5'b11111, sz, l, m, rg[3:0], oc, h, 1'b0, 5'd1, 5'd2};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; inValid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  // drive one op; outputs sampled at the following negedge
  task automatic doOp(input logic [31:0] ins, input logic [31:0] a,
                      input logic [127:0] rm, input logic [63:0] ac);
    @(negedge clk);
    instr = ins; opA = a; regM = rm; acc = ac; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        testsRun++; testsFail++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
        $finish;
      end
    end
  end

  initial begin
    logic [127:0] prevRes;
    logic [127:0] rm;
    logic [2:0]  ln;
    logic [31:0] a;
    doReset();
    // R11: reset state
    check(!outValid && !wrEn && !undef && !satFlag && result == '0, "R11 reset state",
          {outValid, wrEn, undef, satFlag}, 4'b0);

    // vector table: R2..R9
    for (int i = 0; i < NV; i++) begin
      logic [205:0] v;
      v = VEC[i];
      doReset();
      ln = v[200:198];
      rm = {4{32'h5A5A5A5A}};
      if (v[204:203] == 2'b01) begin
        rm[ln*16 +: 16] = v[144:129];
        a = {16'hBEEF, v[176:161]};
      end else begin
        rm[ln*32 +: 32] = v[160:129];
        a = v[192:161];
      end
      doOp(mkInstr(v[205], v[204:203], v[202:201], ln, v[197:193]), a, rm, v[128:65]);
      check(result == {64'd0, v[64:1]}, $sformatf("R6 R7 R8 row %0d result", i),
            result, {64'd0, v[64:1]});
      check(satFlag == v[0], $sformatf("R9 row %0d satFlag", i), 128'(satFlag), 128'(v[0]));
      check(wrEn && outValid && !undef, $sformatf("R10 row %0d strobes", i),
            {outValid, wrEn, undef}, 3'b110);
      check(srcRegNum == v[197:193],
            $sformatf("%s row %0d srcRegNum", v[205] ? "R3 R4 R5" : "R2", i),
            128'(srcRegNum), 128'(v[197:193]));
    end

    // R10: outValid not before the capturing edge
    doReset();
    @(negedge clk);
    instr = mkInstr(1'b0, 2'b01, 2'd0, 3'd0, 5'd1); opA = 32'h2; regM = 128'h3; acc = '0;
    inValid = 1'b1;
    #1 check(!outValid, "R10 no early outValid", 128'(outValid), 128'd0);
    @(negedge clk); inValid = 1'b0;
    check(outValid && result == 128'd12, "R10 result after one cycle", result, 128'd12);
    @(negedge clk);
    check(!outValid, "R10 single-cycle outValid", 128'(outValid), 128'd0);

    // R1: size 00 after saturation keeps result and flag
    doOp(mkInstr(1'b0, 2'b01, 2'd0, 3'd0, 5'd1), 32'h8000, 128'h8000, 64'd0);
    prevRes = result;
    doOp(mkInstr(1'b0, 2'b00, 2'd0, 3'd0, 5'd1), 32'h5, 128'h5, 64'd0);
    check(undef && !wrEn && result == prevRes && satFlag, "R1 size 00 no effect",
          result, prevRes);

    // R9: non-saturating op after saturation leaves flag set
    doOp(mkInstr(1'b0, 2'b01, 2'd0, 3'd0, 5'd1), 32'h1, 128'h1, 64'd0);
    check(satFlag && result == 128'd2, "R9 sticky over clean op", {result[126:0], satFlag},
          {127'd2, 1'b1});

    // R11: reset clears the flag; R1: size 11 with saturating operands no change
    doReset();
    check(!satFlag, "R11 flag cleared", 128'(satFlag), 128'd0);
    doOp(mkInstr(1'b0, 2'b11, 2'd0, 3'd0, 5'd1), 32'h80000000, 128'h80000000, 64'd0);
    check(undef && !wrEn && !satFlag && result == '0, "R1 size 11 no effect",
          {result[125:0], undef, satFlag}, 128'd2);

    // R2: broken fixed field (bits 11:10 nonzero) is undefined
    doOp(mkInstr(1'b0, 2'b01, 2'd0, 3'd0, 5'd1) | 32'h0000_0800, 32'h1, 128'h1, 64'd0);
    check(undef && !wrEn, "R2 bad fixed field undef", {undef, wrEn}, 2'b10);
    // R3: by-element with bit 10 set is undefined
    doOp(mkInstr(1'b1, 2'b01, 2'd0, 3'd0, 5'd1) | 32'h0000_0400, 32'h1, 128'h1, 64'd0);
    check(undef && !wrEn && result == '0, "R3 bad bit10 undef", {undef, wrEn}, 2'b10);
    // R2: opcode outside the three is undefined
    doOp({3'b010, 5'b11110, 2'b01, 1'b1, 5'd1, 4'b0001, 2'b00, 5'd1, 5'd2}, 32'h1,
         128'h1, 64'd0);
    check(undef && !wrEn, "R2 bad opcode undef", {undef, wrEn}, 2'b10);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule